// File: doc/BRIEF.md
# Paged Segment Address Translator

This block converts a two-part logical address (a segment number and an offset within that segment) into a physical address. Each segment is paged on its own. The translator first reads the segment's descriptor from a descriptor table, whose start address comes from a base input sampled when the request is accepted. The descriptor gives the segment's length and the start of its private page table. The offset is checked against that length. A passing offset is then split into a page index and an in-page displacement, and a second read fetches the page entry that supplies the frame number.

Both table reads share one memory read port, which uses a request/valid handshake with any latency. Only one translation is handled at a time. Every translation ends with a single-cycle response that carries a two-bit status and, on success, the physical address. A processor pipeline or a bus bridge uses the block by presenting a request when `req_ready` is high and waiting for `rsp_valid`.

Top module: `pst_translator`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the block is idle, and it stays low from acceptance until the cycle after the response.
- R2: The first memory read of a translation uses address `stbr + req_seg`, where the table base and the memory addresses both count 64-bit words. `stbr` is sampled at acceptance.
- R3: The segment length is descriptor bits 16:0, and descriptor bits 31:17 are ignored. If the offset is greater than or equal to the length, the response has status 1 and `rsp_paddr` = 0, and no second read is issued. A length of 0 rejects every offset, and a length of 65536 accepts every offset.
- R4: If the offset is in bounds, exactly one more read follows, at address `descriptor[63:32] + offset[15:10]`.
- R5: A page entry with bit 31 clear gives status 2 and `rsp_paddr` = 0.
- R6: A page entry with bit 31 set gives status 0 and `rsp_paddr = {entry[21:0], offset[9:0]}`. Entry bits 30:22 and 63:32 are ignored.
- R7: `rsp_valid` is high for exactly one cycle. That cycle directly follows the clock edge that takes the final read data of the translation.
- R8: `mem_rd_req` stays high with a stable `mem_rd_addr` until the edge at which `mem_rd_valid` is seen.
- R9: After reset, `req_ready` = 1, `rsp_valid` = 0 and `mem_rd_req` = 0.
- R10: The status code is never 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stbr | input | 32 | Word address of the segment descriptor table |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Idle and able to accept a request |
| req_seg | input | 18 | Segment number |
| req_off | input | 16 | Offset within the segment |
| mem_rd_req | output | 1 | Table read request |
| mem_rd_addr | output | 32 | Table read word address |
| mem_rd_valid | input | 1 | Read data is present |
| mem_rd_data | input | 64 | Read data |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_status | output | 2 | 0 ok, 1 length violation, 2 page not present |
| rsp_paddr | output | 32 | Physical address, zero unless status is 0 |

## Verification
A read request appears in the cycle after acceptance. A second read request appears in the cycle after the descriptor data edge. The response is due exactly one cycle after the edge that takes the last read data, whatever latency the memory model used. The bench's memory model stamps the cycle of each data beat and records every address it serves. The bench samples outputs at a fixed offset after the falling edge, so each check compares the response cycle with the stamp plus one. It also compares the recorded read count and addresses with values computed from the segment number, the offset and the table contents the model generates.

// File: rtl/pst_pkg.sv
package pst_pkg;
   typedef enum logic [1:0] {
      PST_OK     = 2'd0,
      PST_LEN    = 2'd1,
      PST_NOPAGE = 2'd2
   } pst_status_e;

   typedef enum logic [1:0] {
      W_IDLE,
      W_SEG,
      W_PAGE,
      W_RESP
   } pst_walk_e;
endpackage

// File: rtl/pst_split.sv
module pst_split #(
   parameter int OFF_W  = 16,
   parameter int DISP_W = 10,
   localparam int LEN_W = OFF_W + 1,
   localparam int PG_W  = OFF_W - DISP_W
) (
   input  logic [OFF_W-1:0]  off,
   input  logic [LEN_W-1:0]  seg_len,
   output logic              in_bounds,
   output logic [PG_W-1:0]   page,
   output logic [DISP_W-1:0] disp
);
   // length is one bit wider than the offset so a full-size segment fits
   assign in_bounds = {1'b0, off} < seg_len;
   assign page      = off[OFF_W-1:DISP_W];
   assign disp      = off[DISP_W-1:0];
endmodule

// File: rtl/pst_tbl_addr.sv
module pst_tbl_addr #(
   parameter int ADDR_W    = 32,
   parameter int IDX_W     = 18,
   parameter bit WORD_ADDR = 1'b1,
   parameter int ENT_LG2   = 3
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);
   localparam int PAD_W = ADDR_W - IDX_W;

   logic [ADDR_W-1:0] idx_ext;
   assign idx_ext = {{PAD_W{1'b0}}, idx};

   generate
      if (WORD_ADDR) begin : g_word
         assign addr = base + idx_ext;
      end else begin : g_byte
         assign addr = base + (idx_ext << ENT_LG2);
      end
   endgenerate
endmodule

// File: rtl/pst_walk.sv
module pst_walk
   import pst_pkg::*;
#(
   parameter int SEG_W       = 18,
   parameter int OFF_W       = 16,
   parameter int DISP_W      = 10,
   parameter int ADDR_W      = 32,
   parameter int MEM_DW      = 64,
   parameter int FRAME_W     = 22,
   parameter int PTB_LSB     = 32,
   parameter int PTE_VLD_BIT = 31,
   localparam int PADDR_W    = FRAME_W + DISP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [SEG_W-1:0]   req_seg,
   input  logic [OFF_W-1:0]   req_off,
   input  logic [ADDR_W-1:0]  stbr,
   output logic               req_ready,
   output logic [SEG_W-1:0]   seg_q,
   output logic [OFF_W-1:0]   off_q,
   output logic [ADDR_W-1:0]  stbr_q,
   output logic [ADDR_W-1:0]  ptb_q,
   input  logic [ADDR_W-1:0]  ste_addr,
   input  logic [ADDR_W-1:0]  pte_addr,
   input  logic               in_bounds,
   input  logic [DISP_W-1:0]  disp,
   output logic               mem_rd_req,
   output logic [ADDR_W-1:0]  mem_rd_addr,
   input  logic               mem_rd_valid,
   input  logic [MEM_DW-1:0]  mem_rd_data,
   output logic               rsp_valid,
   output logic [1:0]         rsp_status,
   output logic [PADDR_W-1:0] rsp_paddr
);
   pst_walk_e         state;
   pst_status_e       status_q;
   logic [PADDR_W-1:0] paddr_q;

   logic unused_pte_bits;
   assign unused_pte_bits = ^mem_rd_data[PTE_VLD_BIT-1:FRAME_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= W_IDLE;
         seg_q    <= '0;
         off_q    <= '0;
         stbr_q   <= '0;
         ptb_q    <= '0;
         status_q <= PST_OK;
         paddr_q  <= '0;
      end else begin
         unique case (state)
            W_IDLE: begin
               if (req_valid) begin
                  seg_q  <= req_seg;
                  off_q  <= req_off;
                  stbr_q <= stbr;
                  state  <= W_SEG;
               end
            end
            W_SEG: begin
               if (mem_rd_valid) begin
                  if (in_bounds) begin
                     ptb_q <= mem_rd_data[PTB_LSB +: ADDR_W];
                     state <= W_PAGE;
                  end else begin
                     status_q <= PST_LEN;
                     paddr_q  <= '0;
                     state    <= W_RESP;
                  end
               end
            end
            W_PAGE: begin
               if (mem_rd_valid) begin
                  if (mem_rd_data[PTE_VLD_BIT]) begin
                     status_q <= PST_OK;
                     paddr_q  <= {mem_rd_data[FRAME_W-1:0], disp};
                  end else begin
                     status_q <= PST_NOPAGE;
                     paddr_q  <= '0;
                  end
                  state <= W_RESP;
               end
            end
            default: state <= W_IDLE;
         endcase
      end
   end

   assign req_ready   = (state == W_IDLE);
   assign mem_rd_req  = (state == W_SEG) || (state == W_PAGE);
   assign mem_rd_addr = (state == W_PAGE) ? pte_addr : ste_addr;
   assign rsp_valid   = (state == W_RESP);
   assign rsp_status  = status_q;
   assign rsp_paddr   = paddr_q;
endmodule

// File: rtl/pst_translator.sv
module pst_translator #(
   parameter int SEG_W       = 18,
   parameter int OFF_W       = 16,
   parameter int DISP_W      = 10,
   parameter int ADDR_W      = 32,
   parameter int MEM_DW      = 64,
   parameter int FRAME_W     = 22,
   parameter int PTB_LSB     = 32,
   parameter int PTE_VLD_BIT = 31,
   parameter bit WORD_ADDR   = 1'b1,
   localparam int LEN_W      = OFF_W + 1,
   localparam int PG_W       = OFF_W - DISP_W,
   localparam int PADDR_W    = FRAME_W + DISP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  stbr,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [SEG_W-1:0]   req_seg,
   input  logic [OFF_W-1:0]   req_off,
   output logic               mem_rd_req,
   output logic [ADDR_W-1:0]  mem_rd_addr,
   input  logic               mem_rd_valid,
   input  logic [MEM_DW-1:0]  mem_rd_data,
   output logic               rsp_valid,
   output logic [1:0]         rsp_status,
   output logic [PADDR_W-1:0] rsp_paddr
);
   generate
      if (OFF_W <= DISP_W) begin : g_bad_split
         initial $fatal(1, "offset must be wider than displacement");
      end
      if (SEG_W >= ADDR_W || PG_W >= ADDR_W) begin : g_bad_index
         initial $fatal(1, "table index wider than address");
      end
      if (MEM_DW != PTB_LSB + ADDR_W) begin : g_bad_dw
         initial $fatal(1, "page-table base must occupy the top of the word");
      end
      if (PTB_LSB < LEN_W || PTE_VLD_BIT <= FRAME_W || PTE_VLD_BIT >= PTB_LSB) begin : g_bad_fields
         initial $fatal(1, "descriptor or page entry fields overlap");
      end
   endgenerate

   logic [SEG_W-1:0]  seg_q;
   logic [OFF_W-1:0]  off_q;
   logic [ADDR_W-1:0] stbr_q;
   logic [ADDR_W-1:0] ptb_q;
   logic [ADDR_W-1:0] ste_addr;
   logic [ADDR_W-1:0] pte_addr;
   logic              in_bounds;
   logic [PG_W-1:0]   page;
   logic [DISP_W-1:0] disp;

   pst_split #(.OFF_W(OFF_W), .DISP_W(DISP_W)) u_split (
      .off       (off_q),
      .seg_len   (mem_rd_data[LEN_W-1:0]),
      .in_bounds (in_bounds),
      .page      (page),
      .disp      (disp)
   );

   pst_tbl_addr #(.ADDR_W(ADDR_W), .IDX_W(SEG_W), .WORD_ADDR(WORD_ADDR), .ENT_LG2(3)) u_seg_addr (
      .base (stbr_q),
      .idx  (seg_q),
      .addr (ste_addr)
   );

   pst_tbl_addr #(.ADDR_W(ADDR_W), .IDX_W(PG_W), .WORD_ADDR(WORD_ADDR), .ENT_LG2(3)) u_pg_addr (
      .base (ptb_q),
      .idx  (page),
      .addr (pte_addr)
   );

   pst_walk #(
      .SEG_W(SEG_W), .OFF_W(OFF_W), .DISP_W(DISP_W), .ADDR_W(ADDR_W), .MEM_DW(MEM_DW),
      .FRAME_W(FRAME_W), .PTB_LSB(PTB_LSB), .PTE_VLD_BIT(PTE_VLD_BIT)
   ) u_walk (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_seg      (req_seg),
      .req_off      (req_off),
      .stbr         (stbr),
      .req_ready    (req_ready),
      .seg_q        (seg_q),
      .off_q        (off_q),
      .stbr_q       (stbr_q),
      .ptb_q        (ptb_q),
      .ste_addr     (ste_addr),
      .pte_addr     (pte_addr),
      .in_bounds    (in_bounds),
      .disp         (disp),
      .mem_rd_req   (mem_rd_req),
      .mem_rd_addr  (mem_rd_addr),
      .mem_rd_valid (mem_rd_valid),
      .mem_rd_data  (mem_rd_data),
      .rsp_valid    (rsp_valid),
      .rsp_status   (rsp_status),
      .rsp_paddr    (rsp_paddr)
   );
endmodule

// File: rtl/pst_translator_chk.sv
module pst_translator_chk #(
   parameter int OFF_W   = 16,
   parameter int DISP_W  = 10,
   parameter int ADDR_W  = 32,
   parameter int PADDR_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic [OFF_W-1:0]   req_off,
   input logic               mem_rd_req,
   input logic [ADDR_W-1:0]  mem_rd_addr,
   input logic               mem_rd_valid,
   input logic               rsp_valid,
   input logic [1:0]         rsp_status,
   input logic [PADDR_W-1:0] rsp_paddr
);
   logic [OFF_W-1:0] off_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) off_seen <= '0;
      else if (req_valid && req_ready) off_seen <= req_off;
   end

   assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_len_fault_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == 2'd1) |-> (rsp_paddr == '0));

   assert_page_fault_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == 2'd2) |-> (rsp_paddr == '0));

   assert_disp_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == 2'd0) |-> (rsp_paddr[DISP_W-1:0] == off_seen[DISP_W-1:0]));

   assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_no_read_at_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !mem_rd_req);

   assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

   assert_status_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_status != 2'd3));
endmodule

bind pst_translator pst_translator_chk #(
   .OFF_W(OFF_W), .DISP_W(DISP_W), .ADDR_W(ADDR_W), .PADDR_W(PADDR_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .req_off      (req_off),
   .mem_rd_req   (mem_rd_req),
   .mem_rd_addr  (mem_rd_addr),
   .mem_rd_valid (mem_rd_valid),
   .rsp_valid    (rsp_valid),
   .rsp_status   (rsp_status),
   .rsp_paddr    (rsp_paddr)
);

// File: tb/pst_translator_tb.sv
module pst_translator_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] stbr = 32'h100;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [17:0] req_seg = '0;
   logic [15:0] req_off = '0;
   logic        mem_rd_req;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_valid = 1'b0;
   logic [63:0] mem_rd_data = '0;
   logic        rsp_valid;
   logic [1:0]  rsp_status;
   logic [31:0] rsp_paddr;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int ncyc = 0;
   int nreads = 0;
   int last_vcyc = 0;
   int lat_sel = 0;
   int lat_cnt = 0;
   logic [31:0] ste_seen, pte_seen;

   localparam int PT_REGION = 32'h0010_0000;

   always #10 clk = ~clk;

   pst_translator u_dut (
      .clk(clk), .rst_n(rst_n), .stbr(stbr), .req_valid(req_valid), .req_ready(req_ready),
      .req_seg(req_seg), .req_off(req_off), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid),
      .rsp_status(rsp_status), .rsp_paddr(rsp_paddr)
   );

   function automatic int seg_len(int s);
      int m = s % 8;
      if (m == 0) return 0;
      if (m == 7) return 65536;
      return m * 9001;
   endfunction

   function automatic int pt_base(int s);
      return PT_REGION + s * 64;
   endfunction

   function automatic bit pg_ok(int s, int p);
      return ((s + p) % 5) != 0;
   endfunction

   function automatic logic [21:0] pg_frame(int s, int p);
      int f = s * 97 + p * 3 + 1;
      return f[21:0];
   endfunction

   function automatic logic [63:0] mem_word(logic [31:0] a);
      int s, p, len;
      logic [31:0] pb;
      if (a < PT_REGION) begin
         s   = int'(a - stbr);
         len = seg_len(s);
         pb  = pt_base(s);
         return {pb, 15'h5A5A, len[16:0]};
      end
      s = int'(a - PT_REGION) >> 6;
      p = int'(a - PT_REGION) & 63;
      return {32'hDEAD_BEEF, pg_ok(s, p), 9'h1FF, pg_frame(s, p)};
   endfunction

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // memory model: variable latency 0..3 extra cycles, data driven at falling edge
   initial begin
      forever begin
         @(negedge clk);
         ncyc++;
         if (mem_rd_valid) mem_rd_valid = 1'b0;
         else if (mem_rd_req) begin
            if (lat_cnt == 0) begin
               mem_rd_data  = mem_word(mem_rd_addr);
               mem_rd_valid = 1'b1;
               nreads++;
               if (nreads == 1) ste_seen = mem_rd_addr;
               else pte_seen = mem_rd_addr;
               last_vcyc = ncyc;
               lat_sel   = (lat_sel + 1) % 4;
               lat_cnt   = lat_sel;
            end else lat_cnt--;
         end
      end
   end

   task automatic run(int s, int off);
      int len = seg_len(s);
      int p = off >> 10;
      int t = 0;
      bit fault_len = (off >= len);
      logic [1:0]  exp_st;
      logic [31:0] exp_pa;
      logic [15:0] o16 = off[15:0];
      if (fault_len) begin exp_st = 2'd1; exp_pa = 0; end
      else if (!pg_ok(s, p)) begin exp_st = 2'd2; exp_pa = 0; end
      else begin exp_st = 2'd0; exp_pa = {pg_frame(s, p), o16[9:0]}; end

      @(negedge clk); #1;
      while (!req_ready && t < 50) begin @(negedge clk); #1; t++; end
      nreads = 0;
      req_seg = s[17:0]; req_off = o16; req_valid = 1'b1;
      @(negedge clk); #1;
      req_valid = 1'b0;
      chk(!req_ready, "R1 busy after accept", req_ready, 0);
      t = 0;
      while (!rsp_valid && t < 200) begin @(negedge clk); #1; t++; end
      if (!rsp_valid) begin
         chk(0, "R7 response timeout", 0, 1);
         return;
      end
      chk(ncyc == last_vcyc + 1, "R7 response cycle", ncyc, last_vcyc + 1);
      chk(ste_seen == stbr + s, "R2 descriptor address", ste_seen, stbr + s);
      if (fault_len) begin
         chk(nreads == 1, "R3 single read on length fault", nreads, 1);
         chk(rsp_status == exp_st && rsp_paddr == exp_pa, "R3 length fault", {rsp_status, rsp_paddr}, {exp_st, exp_pa});
      end else begin
         chk(nreads == 2, "R4 two reads", nreads, 2);
         chk(pte_seen == pt_base(s) + p, "R4 page entry address", pte_seen, pt_base(s) + p);
         if (exp_st == 2'd2)
            chk(rsp_status == exp_st && rsp_paddr == exp_pa, "R5 page not present", {rsp_status, rsp_paddr}, {exp_st, exp_pa});
         else
            chk(rsp_status == exp_st && rsp_paddr == exp_pa, "R6 physical address", {rsp_status, rsp_paddr}, {exp_st, exp_pa});
      end
      chk(rsp_status != 2'd3, "R10 status legal", rsp_status, 0);
      @(negedge clk); #1;
      chk(!rsp_valid && req_ready, "R7 single cycle response", {rsp_valid, req_ready}, 2'b01);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int segs [7] = '{0, 1, 2, 3, 5, 7, 32'h3FFFF};
      repeat (3) @(negedge clk);
      #1;
      chk(req_ready && !rsp_valid && !mem_rd_req, "R9 reset outputs", {req_ready, rsp_valid, mem_rd_req}, 3'b100);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(req_ready && !rsp_valid && !mem_rd_req, "R9 idle after reset", {req_ready, rsp_valid, mem_rd_req}, 3'b100);

      for (int b = 0; b < 2; b++) begin
         stbr = (b == 0) ? 32'h100 : 32'h2_0000;
         foreach (segs[i]) begin
            int len = seg_len(segs[i]);
            run(segs[i], 0);
            run(segs[i], 1023);
            run(segs[i], 1024);
            run(segs[i], 16'hFFFF);
            run(segs[i], 16'h8000);
            if (len > 0) run(segs[i], len - 1);
            if (len > 0 && len <= 16'hFFFF) run(segs[i], len);
         end
      end
      // full page sweep of a maximum-length segment
      for (int p = 0; p < 64; p++) run(15, p * 1024 + ((p * 37) % 1024));

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule